// File: doc/BRIEF.md
# Output-Side Credit Counter Link

This block sits at the output of a switching module and tracks how many free slots remain in the receiver buffer at the far end of the link. A registered credit count produces one `ready` indication that goes to every input. An input forwards a flit only while `ready` is high, the same way it would in a ready/valid handshake. Each forwarded flit costs one credit. The receiver hands one credit back each time its consumer dequeues a flit.

The forward data path holds `FWD_STAGES` pipeline registers that cannot stall, followed by a small receiver FIFO of `DEPTH` slots. The credit-return path holds `BWD_STAGES` registers before the counter. `ready` depends only on the stored count, so the loop from credit use through ready, request and grant back to credit use is cut at a register. When `DEPTH` is at least `FWD_STAGES + BWD_STAGES + 2`, the link carries one flit per clock indefinitely while the sink drains continuously.

Top module: `credit_link`

## Requirements
- R1: After reset `ready` is 1, `out_valid` is 0 and the credit count equals `DEPTH`.
- R2: `ready` is 1 exactly when the credit count is above zero. Starting from full credit with no dequeues, it drops after exactly `DEPTH` accepted flits.
- R3: `ready` is taken from the registered count alone. Raising `in_valid` does not change `ready` before the next clock edge; the effect of a take appears only after that edge.
- R4: A flit is accepted at an edge only when `in_valid` and `ready` are both 1. `in_valid` asserted while `ready` is 0 produces no flit and consumes no credit.
- R5: A flit accepted at edge n is written into the receiver FIFO at edge n+`FWD_STAGES`. It shows on `out_valid`/`out_data` right after that edge if the FIFO was empty.
- R6: A dequeue (`out_deq` with `out_valid`) at edge n restores one credit at edge n+`BWD_STAGES`. `ready` reflects that credit right after that edge.
- R7: A take and a returned credit in the same cycle leave the count unchanged.
- R8: With `DEPTH` >= `FWD_STAGES`+`BWD_STAGES`+2 and `out_deq` held at 1, `ready` stays 1 and one flit is accepted every cycle.
- R9: Flits leave in the order they were accepted, with none lost, duplicated or overwritten in the receiver FIFO.
- R10: The credit count never goes below 0 and never exceeds `DEPTH`.
- R11: `out_deq` while `out_valid` is 0 is ignored and returns no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input offers a flit |
| in_data | input | DATA_W | Flit payload from the granted input |
| ready | output | 1 | Credit available, broadcast to all inputs |
| out_valid | output | 1 | Receiver FIFO holds a flit |
| out_data | output | DATA_W | Head flit of the receiver FIFO |
| out_deq | input | 1 | Sink takes the head flit |

## Verification
The hardest state to reach is the one where credits are exhausted while flits are still in flight on both pipelines. This is where an off-by-one in the return delay or a combinational ready path would show. The bench gets there by filling the link with the sink stalled. It then releases exactly one dequeue and counts edges until `ready` returns, and spends the single restored credit while holding `in_valid` high against a low `ready`. A long back-to-back stream with the sink always draining then exercises the steady state where a take and a return coincide on every edge.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;

    typedef enum logic [1:0] {
        CR_HOLD = 2'd0,
        CR_TAKE = 2'd1,
        CR_GIVE = 2'd2
    } credit_op_e;

    function automatic int unsigned count_bits(input int unsigned depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/link_delay.sv
module link_delay #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [W-1:0] stage_d [STAGES];
            logic [W-1:0] stage_q [STAGES];

            always_comb begin
                stage_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stage_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < STAGES; i++) begin
                        stage_q[i] <= stage_d[i];
                    end
                end
            end

            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/credit_counter.sv
module credit_counter
    import credit_link_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic ready
);
    localparam int unsigned CW = count_bits(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    credit_op_e op;

    always_comb begin
        state_d = state_q;
        unique case ({give, take})
            2'b01:   op = CR_TAKE;
            2'b10:   op = CR_GIVE;
            default: op = CR_HOLD;
        endcase
        case (op)
            CR_TAKE: state_d.count = state_q.count - 1'b1;
            CR_GIVE: state_d.count = state_q.count + 1'b1;
            default: state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{count: FULL};
        else        state_q <= state_d;
    end

    assign ready = (state_q.count != '0);

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give) |-> (state_q.count != '0));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |-> (state_q.count < FULL));

    assert_take_give_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> $stable(state_q.count));

    assert_last_credit_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && state_q.count == CW'(1)) |=> !ready);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import credit_link_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = count_bits(DEPTH);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    typedef struct packed {
        logic [IW-1:0] wr_idx;
        logic [IW-1:0] rd_idx;
        logic [CW-1:0] used;
    } fifo_state_t;

    fifo_state_t state_d, state_q;
    logic [W-1:0] slot_q [DEPTH];

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.wr_idx = (state_q.wr_idx == LAST) ? '0 : state_q.wr_idx + 1'b1;
        end
        if (rd_en) begin
            state_d.rd_idx = (state_q.rd_idx == LAST) ? '0 : state_q.rd_idx + 1'b1;
        end
        case ({wr_en, rd_en})
            2'b10:   state_d.used = state_q.used + 1'b1;
            2'b01:   state_d.used = state_q.used - 1'b1;
            default: state_d.used = state_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[state_q.wr_idx] <= wr_data;
    end

    assign rd_valid = (state_q.used != '0);
    assign rd_data  = slot_q[state_q.rd_idx];

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q.used < CW'(DEPTH)));

    assert_no_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (state_q.used != '0));
endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FWD_STAGES = 1,
    parameter int unsigned BWD_STAGES = 1,
    parameter int unsigned DEPTH      = FWD_STAGES + BWD_STAGES + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_deq
);
    localparam int unsigned FW = DATA_W + 1;

    logic              take;
    logic              deq_fire;
    logic              give;
    logic [FW-1:0]     fwd_in;
    logic [FW-1:0]     fwd_out;

    assign take     = in_valid && ready;
    assign deq_fire = out_deq && out_valid;
    assign fwd_in   = {take, in_data};

    credit_counter #(.DEPTH(DEPTH)) u_credits (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .give  (give),
        .ready (ready)
    );

    link_delay #(.W(FW), .STAGES(FWD_STAGES)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fwd_in),
        .dout  (fwd_out)
    );

    rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fwd_out[FW-1]),
        .wr_data  (fwd_out[DATA_W-1:0]),
        .rd_en    (deq_fire),
        .rd_valid (out_valid),
        .rd_data  (out_data)
    );

    link_delay #(.W(1), .STAGES(BWD_STAGES)) u_bwd (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (deq_fire),
        .dout  (give)
    );

    assert_blocked_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ready) |-> !fwd_in[FW-1]);
endmodule

// File: tb/credit_link_test.sv
`timescale 1ns/1ps
module credit_link_test;
    localparam int unsigned DW = 16;
    localparam int unsigned FS = 1;
    localparam int unsigned BS = 1;
    localparam int unsigned DP = FS + BS + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_deq = 1'b0;

    int checks = 0;
    int fails  = 0;
    int tx_seq = 0;
    int rx_seq = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    credit_link #(.DATA_W(DW), .FWD_STAGES(FS), .BWD_STAGES(BS), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ready(ready), .out_valid(out_valid), .out_data(out_data), .out_deq(out_deq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R9: every departing flit must carry the next sequence number
    always @(posedge clk) begin
        if (rst_n && out_valid && out_deq) begin
            check(out_data == DW'(rx_seq), "R9 order", int'(out_data), rx_seq);
            rx_seq++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic drain();
        out_deq = 1'b1;
        for (int n = 0; n < 200 && rx_seq != tx_seq; n++) @(negedge clk);
        out_deq = 1'b0;
        check(rx_seq == tx_seq, "R9 drained", rx_seq, tx_seq);
        repeat (BS + 3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after release", int'(ready), 1);
    endtask

    task automatic t_fwd_latency();
        in_valid = 1'b1; in_data = DW'(tx_seq);
        @(negedge clk);
        in_valid = 1'b0; tx_seq++;
        for (int j = 0; j < int'(FS); j++) begin
            check(out_valid == 1'b0, "R5 early", int'(out_valid), 0);
            @(negedge clk);
        end
        check(out_valid == 1'b1, "R5 arrival", int'(out_valid), 1);
        check(out_data == DW'(tx_seq - 1), "R5 data", int'(out_data), tx_seq - 1);
        drain();
    endtask

    task automatic fill(output int accepted);
        accepted = 0;
        for (int n = 0; n < 3 * int'(DP) && ready; n++) begin
            in_valid = 1'b1; in_data = DW'(tx_seq);
            @(negedge clk);
            tx_seq++; accepted++;
        end
        in_valid = 1'b0;
    endtask

    task automatic t_backpressure();
        int acc;
        fill(acc);
        check(acc == int'(DP), "R2 credits to zero", acc, DP);
        check(ready == 1'b0, "R2 ready low", int'(ready), 0);
        repeat (FS + 1) @(negedge clk);
        out_deq = 1'b1;
        @(negedge clk);
        out_deq = 1'b0; rx_seq = rx_seq;
        for (int j = 0; j < int'(BS); j++) begin
            check(ready == 1'b0, "R6 not yet", int'(ready), 0);
            @(negedge clk);
        end
        check(ready == 1'b1, "R6 credit back", int'(ready), 1);
        // R3: raising in_valid must not move ready before the edge
        in_valid = 1'b1; in_data = DW'(tx_seq);
        #1;
        check(ready == 1'b1, "R3 no comb path", int'(ready), 1);
        @(negedge clk);
        tx_seq++;
        check(ready == 1'b0, "R3 take seen after edge", int'(ready), 0);
        // R4: keep offering while ready is low
        in_data = 16'hDEAD;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R4 still blocked", int'(ready), 0);
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_refill();
        int acc;
        // R11: dequeue on an empty FIFO must not add credit
        out_deq = 1'b1;
        repeat (3) @(negedge clk);
        out_deq = 1'b0;
        repeat (BS + 2) @(negedge clk);
        fill(acc);
        check(acc == int'(DP), "R11 no spurious credit", acc, DP);
        check(acc == int'(DP), "R4 no credit lost", acc, DP);
        drain();
    endtask

    task automatic t_stream();
        int start = tx_seq;
        int highs = 0;
        out_deq = 1'b1;
        for (int n = 0; n < 40; n++) begin
            in_valid = 1'b1; in_data = DW'(tx_seq);
            if (ready) highs++;
            check(ready == 1'b1, "R8 ready sustained", int'(ready), 1);
            @(negedge clk);
            if (highs > n) tx_seq++;
        end
        in_valid = 1'b0;
        check(tx_seq - start == 40, "R7 one per cycle", tx_seq - start, 40);
        drain();
        check(rx_seq == tx_seq, "R8 all delivered", rx_seq, tx_seq);
    endtask

    initial begin
        t_reset();
        t_fwd_latency();
        t_backpressure();
        t_refill();
        t_stream();
        finish_run();
    end
endmodule